// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character per request into an asynchronous serial frame on a single output line. Bit timing comes from an external baud tick, and every bit lasts exactly one tick period. A character is 8, 9 or 10 positions long. When parity is enabled, the top position carries the parity bit and the positions below it carry data. The frame ends with one or two stop bits. The data bits can be sent least significant first or most significant first. In both orders the start bit, the parity bit and the stop bits stay where they are.

The block can also send a break, which is a continuous low level. Its length comes from the frame format and from an extended-break select. After the break the line is held high for one bit time before the next request is taken. The bit-order select and the extended-break select are captured only while the transmitter is disabled. All other format inputs are captured together with the character, or with the break request.

Top module: `uart_frame_tx`

## Requirements
- R1: `txReady` is high only while no frame is in progress, `txEnable` is high and `breakReq` is low. When `txReady` is low, `txValid` is ignored.
- R2: After reset the line is high. A frame is one low start bit, then the character positions, then the stop bits, which are high. Each bit lasts exactly one baud tick period, and the first bit begins at the first tick after the request is accepted.
- R3: When the captured bit order is 0 (least significant first), data bit 0 of `txData` is the first bit after the start bit.
- R4: When the captured bit order is 1 (most significant first), the highest data bit is the first bit after the start bit: bit 9, 8, 7 or 6, depending on length and parity. Parity, start and stop bits keep their positions.
- R5: With `parityEn` set, the last character position carries the XOR of the data bits. That XOR is inverted when `parityOdd` is 1 (odd parity).
- R6: `dataLen` selects the character length: 0 gives 8 positions, 1 gives 9, and 2 or 3 give 10. Parity, when enabled, takes one of these positions.
- R7: `twoStop` = 0 gives one stop bit and `twoStop` = 1 gives two.
- R8: A normal break is low for 10 bit times (8 positions, one stop bit), 11 (9 and one, or 8 and two), 12 (9 and two, or 10 and one) or 13 (10 and two).
- R9: With the captured extended-break select at 1, every break length in R8 grows by 3 bit times.
- R10: A break is followed by exactly one high bit time before the block returns to idle. A break request in idle takes priority over a pending character.
- R11: `msbFirst` and `longBreak` are captured only while `txEnable` is low. Changes made while the transmitter is enabled have no effect.
- R12: `busy` is high from the cycle after acceptance until the last bit period ends, and it is high whenever the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle bit-timing pulse |
| txEnable | input | 1 | Transmitter enable |
| dataLen | input | 2 | Character length select (0:8, 1:9, 2/3:10) |
| twoStop | input | 1 | Two stop bits when 1 |
| parityEn | input | 1 | Parity in top character position when 1 |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| msbFirst | input | 1 | Data order select, captured while disabled |
| longBreak | input | 1 | Extended break select, captured while disabled |
| txData | input | 10 | Character data, right-aligned |
| txValid | input | 1 | Character request |
| txReady | output | 1 | Character accepted when high together with txValid |
| breakReq | input | 1 | Break request, sampled in idle |
| txLine | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame or break in progress |

## Verification
A corrupted shift register or bit counter is visible on the line within the frame itself. It shows up as a misplaced data bit, a parity bit in the wrong slot, a missing stop bit, or a break that is one bit time off. The bench therefore samples every bit period of every frame and checks the first idle sample after it. A stuck state machine is visible no more than one bit time later: `busy` stays high or `txReady` stays low when the frame should have ended. A configuration capture that leaks while enabled changes the bit order, or the break length, of the very next frame.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;
  localparam int CHAR_W   = 10;                 // widest character
  localparam int STOP_MAX = 2;
  localparam int EXT_BRK  = 3;                  // extra bit times of extended break
  localparam int FRAME_W  = 1 + CHAR_W + STOP_MAX + EXT_BRK + 1; // longest break plus idle bit
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int IDX_W    = $clog2(CHAR_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } txState_t;

  typedef struct packed {
    logic loadChar;
    logic loadBreak;
    logic emitBit;
    logic finish;
  } txStrobe_t;
endpackage

// File: rtl/uart_ftx_datapath.sv
module uart_ftx_datapath
  import uart_ftx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [CHAR_W-1:0] txData,
  input  logic [1:0]        dataLen,
  input  logic              twoStop,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              msbFirstQ,
  input  logic              longBreakQ,
  output logic              txLine,
  output logic              lastBit
);
  logic [CNT_W-1:0]   charLen, dataBits, charCount, breakBits;
  logic [FRAME_W-1:0] charFrame, breakFrame, frameReg;
  logic [CNT_W-1:0]   remain;
  logic [IDX_W-1:0]   pick;
  logic               parAcc;

  always_comb begin
    unique case (dataLen)
      2'd0:    charLen = CNT_W'(8);
      2'd1:    charLen = CNT_W'(9);
      default: charLen = CNT_W'(10);
    endcase
    dataBits  = charLen - CNT_W'(parityEn);
    charCount = charLen + CNT_W'(1) + CNT_W'(1) + CNT_W'(twoStop);
    breakBits = charLen + CNT_W'(1) + CNT_W'(1) + CNT_W'(twoStop)
              + (longBreakQ ? CNT_W'(EXT_BRK) : CNT_W'(0));
  end

  // character frame, bit 0 leaves first; unused upper bits stay high (stop/idle)
  always_comb begin
    charFrame    = '1;
    charFrame[0] = 1'b0;
    parAcc       = parityOdd;
    pick         = '0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (CNT_W'(i) < dataBits) begin
        pick = msbFirstQ ? IDX_W'(dataBits - CNT_W'(1) - CNT_W'(i)) : IDX_W'(i);
        charFrame[i + 1] = txData[pick];
        parAcc = parAcc ^ txData[i];
      end
    end
    if (parityEn) charFrame[dataBits + CNT_W'(1)] = parAcc;
  end

  // break: low for breakBits, then high
  always_comb begin
    for (int i = 0; i < FRAME_W; i++) begin
      breakFrame[i] = (CNT_W'(i) >= breakBits);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
      remain   <= '0;
      txLine   <= 1'b1;
    end else begin
      if (strobe.loadChar) begin
        frameReg <= charFrame;
        remain   <= charCount;
      end else if (strobe.loadBreak) begin
        frameReg <= breakFrame;
        remain   <= breakBits + CNT_W'(1);
      end else if (strobe.emitBit) begin
        txLine   <= frameReg[0];
        frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
        remain   <= remain - CNT_W'(1);
      end else if (strobe.finish) begin
        txLine   <= 1'b1;
      end
    end
  end

  assign lastBit = (remain == '0);

  p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    remain <= CNT_W'(FRAME_W));
  p_emit_needs_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitBit |-> !lastBit);
endmodule

// File: rtl/uart_ftx_control.sv
module uart_ftx_control
  import uart_ftx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      txEnable,
  input  logic      txValid,
  input  logic      breakReq,
  input  logic      msbFirst,
  input  logic      longBreak,
  input  logic      lastBit,
  output txStrobe_t strobe,
  output logic      msbFirstQ,
  output logic      longBreakQ,
  output logic      txReady,
  output logic      busy
);
  txState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (txEnable && breakReq) begin
          strobe.loadBreak = 1'b1;
          stateNext        = ST_ARM;
        end else if (txEnable && txValid) begin
          strobe.loadChar = 1'b1;
          stateNext       = ST_ARM;
        end
      end
      ST_ARM: begin
        if (baudTick) begin
          strobe.emitBit = 1'b1;
          stateNext      = ST_SEND;
        end
      end
      default: begin
        if (baudTick) begin
          if (lastBit) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobe.emitBit = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      msbFirstQ  <= 1'b0;
      longBreakQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (!txEnable) begin
        msbFirstQ  <= msbFirst;
        longBreakQ <= longBreak;
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign txReady = (state == ST_IDLE) && txEnable && !breakReq;

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable)) |-> ($stable(msbFirstQ) && $stable(longBreakQ)));
  p_accept_starts_frame_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> busy);
  p_one_load_at_a_time_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadChar, strobe.loadBreak, strobe.emitBit, strobe.finish}));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_ftx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txEnable,
  input  logic [1:0]        dataLen,
  input  logic              twoStop,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              msbFirst,
  input  logic              longBreak,
  input  logic [CHAR_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              breakReq,
  output logic              txLine,
  output logic              busy
);
  txStrobe_t strobe;
  logic      lastBit, msbFirstQ, longBreakQ;

  uart_ftx_control u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .txValid(txValid), .breakReq(breakReq), .msbFirst(msbFirst),
    .longBreak(longBreak), .lastBit(lastBit), .strobe(strobe),
    .msbFirstQ(msbFirstQ), .longBreakQ(longBreakQ), .txReady(txReady), .busy(busy)
  );

  uart_ftx_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData), .dataLen(dataLen),
    .twoStop(twoStop), .parityEn(parityEn), .parityOdd(parityOdd),
    .msbFirstQ(msbFirstQ), .longBreakQ(longBreakQ), .txLine(txLine), .lastBit(lastBit)
  );

  p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(baudTick) |-> $stable(txLine));
  p_low_means_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    !txLine |-> busy);
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rstN, baudTick, txEnable, twoStop, parityEn, parityOdd;
  logic       msbFirst, longBreak, txValid, breakReq;
  logic [1:0] dataLen;
  logic [9:0] txData;
  logic       txReady, txLine, busy;
  int checks = 0, failures = 0, cycles = 0;

  uart_frame_tx dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .dataLen(dataLen), .twoStop(twoStop), .parityEn(parityEn), .parityOdd(parityOdd),
    .msbFirst(msbFirst), .longBreak(longBreak), .txData(txData), .txValid(txValid),
    .txReady(txReady), .breakReq(breakReq), .txLine(txLine), .busy(busy)
  );

  always #2 clk = ~clk;   // 250 MHz

  initial begin
    baudTick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        checks++; failures++;
        $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
        summary();
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected bits of a character frame, index 0 is the start bit
  task automatic buildExpect(input logic [9:0] d, input int len, input bit par, input bit odd,
                             input bit two, input bit msb, output logic [16:0] v, output int n);
    int db;
    bit p;
    db = len - (par ? 1 : 0);
    v = '1;
    v[0] = 1'b0;
    p = odd;
    for (int j = 0; j < db; j++) begin
      v[1 + j] = msb ? d[db - 1 - j] : d[j];
      p = p ^ d[j];
    end
    if (par) v[db + 1] = p;
    n = 1 + len + (two ? 2 : 1);
  endtask

  task automatic waitLow(input string req);
    int t = 0;
    while (txLine !== 1'b0 && t < 40) begin
      @(negedge clk);
      t++;
    end
    check(txLine === 1'b0, req, {31'd0, txLine}, 32'd0);
  endtask

  // collect n bits at mid-period; first sample is the negedge where the line went low
  task automatic collect(input int n, output logic [16:0] got);
    got = '1;
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      got[j] = txLine;
      if (j == 1) check(txReady === 1'b0 && busy === 1'b1, "R1 not ready while busy",
                        {30'd0, txReady, busy}, 32'h1);
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic setFmt(input int len, input bit par, input bit odd, input bit two);
    dataLen   = (len == 8) ? 2'd0 : (len == 9) ? 2'd1 : 2'd2;
    parityEn  = par;
    parityOdd = odd;
    twoStop   = two;
  endtask

  task automatic runChar(input logic [9:0] d, input int len, input bit par, input bit odd,
                         input bit two, input bit msbExp, input string req);
    logic [16:0] exp, got;
    int n;
    @(negedge clk);
    setFmt(len, par, odd, two);
    txData  = d;
    txValid = 1'b1;
    check(txReady === 1'b1, "R1 ready in idle", {31'd0, txReady}, 32'd1);
    @(negedge clk);
    txValid = 1'b0;
    check(busy === 1'b1, "R12 busy after accept", {31'd0, busy}, 32'd1);
    buildExpect(d, len, par, odd, two, msbExp, exp, n);
    waitLow(req);
    collect(n, got);
    check(got == exp, req, {15'd0, got}, {15'd0, exp});
    check(busy === 1'b0 && txLine === 1'b1, "R12 frame ends after last stop bit",
          {30'd0, busy, txLine}, 32'h1);
  endtask

  task automatic runBreak(input int len, input bit two, input int expLen,
                          input bit withChar, input string req);
    logic [16:0] got, exp;
    @(negedge clk);
    setFmt(len, 1'b0, 1'b0, two);
    breakReq = 1'b1;
    txValid  = withChar;
    txData   = 10'h3FF;
    @(negedge clk);
    breakReq = 1'b0;
    txValid  = 1'b0;
    waitLow(req);
    collect(expLen + 1, got);
    exp = '1;
    for (int j = 0; j < expLen; j++) exp[j] = 1'b0;
    check(got == exp, req, {15'd0, got}, {15'd0, exp});
    check(busy === 1'b0 && txLine === 1'b1, "R10 idle bit then idle",
          {30'd0, busy, txLine}, 32'h1);
  endtask

  task automatic setEnable(input bit en, input bit msb, input bit lb);
    @(negedge clk);
    txEnable = 1'b0;
    msbFirst = msb;
    longBreak = lb;
    @(negedge clk);
    txEnable = en;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(txLine === 1'b1 && busy === 1'b0, "R2 idle high after reset", {30'd0, txLine, busy}, 32'h2);
    check(txReady === 1'b0, "R1 not ready while disabled", {31'd0, txReady}, 32'd0);
  endtask

  task automatic t_disabledIgnored();
    @(negedge clk);
    txValid = 1'b1;
    txData  = 10'h000;
    repeat (12) @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0, "R1 valid ignored while disabled",
          {30'd0, txLine, busy}, 32'h2);
    txValid = 1'b0;
  endtask

  task automatic t_cfgFrozen();
    setEnable(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    msbFirst  = 1'b1;     // R11: ignored while enabled
    longBreak = 1'b1;
    runChar(10'h0C1, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R11 order change while enabled ignored");
    runBreak(8, 1'b0, 10, 1'b0, "R11 break select change while enabled ignored");
  endtask

  initial begin
    rstN = 1'b0; txEnable = 1'b0; txValid = 1'b0; breakReq = 1'b0;
    msbFirst = 1'b0; longBreak = 1'b0; txData = '0;
    dataLen = 2'd0; twoStop = 1'b0; parityEn = 1'b0; parityOdd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabledIgnored();

    setEnable(1'b1, 1'b0, 1'b0);
    runChar(10'h0A5, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 LSB-first 8 bits one stop");
    runChar(10'h1B3, 9, 1'b0, 1'b0, 1'b1, 1'b0, "R7 two stop bits, R6 9 bits");
    runChar(10'h0D2, 9, 1'b1, 1'b1, 1'b0, 1'b0, "R5 odd parity 9 positions");

    setEnable(1'b1, 1'b1, 1'b0);
    runChar(10'h043, 8, 1'b1, 1'b0, 1'b0, 1'b1, "R4 MSB-first bit6 first, R5 even parity");
    runChar(10'h2C5, 10, 1'b0, 1'b0, 1'b1, 1'b1, "R4 MSB-first bit9 first, R6 10 bits");
    runChar(10'h19A, 10, 1'b1, 1'b1, 1'b0, 1'b1, "R4 MSB-first with parity, R6 10 positions");

    runBreak(8, 1'b0, 10, 1'b0, "R8 break 8/1 = 10");
    runBreak(9, 1'b0, 11, 1'b0, "R8 break 9/1 = 11");
    runBreak(9, 1'b1, 12, 1'b0, "R8 break 9/2 = 12");
    runBreak(10, 1'b1, 13, 1'b0, "R8 break 10/2 = 13");
    runBreak(8, 1'b0, 10, 1'b1, "R10 break wins over pending char");

    setEnable(1'b1, 1'b0, 1'b1);
    runBreak(8, 1'b0, 13, 1'b0, "R9 extended break 8/1 = 13");
    runBreak(8, 1'b1, 14, 1'b0, "R9 extended break 8/2 = 14");
    runBreak(10, 1'b0, 15, 1'b0, "R9 extended break 10/1 = 15");
    runBreak(10, 1'b1, 16, 1'b0, "R9 extended break 10/2 = 16");

    t_cfgFrozen();
    summary();
  end
endmodule